// File: doc/BRIEF.md
# Corrected Byte Output and Bit-Flip Statistics Stage

This block is the last stage of a block error-correcting decoder. The original received bytes come back from an external delay FIFO. The error-value generator supplies one error byte per FIFO byte. The stage XORs each error byte into its data byte and sends out the corrected block, one byte per clock, one clock after the inputs arrive.

While the block passes through, the stage counts how many bits the correction changed. It keeps two counts: bits turned from 1 to 0, and bits turned from 0 to 1. It marks the first corrected byte of each block. Exactly two clocks after the last byte of a block leaves, it raises a one-clock status strobe that carries both counts and an uncorrectable flag.

The decoder may declare a block uncorrectable. The flag is sampled together with the block-start marker. For such a block every error byte is treated as zero, so the data passes through unmodified and both counts report zero. Idle clocks are allowed between blocks and inside a block. A block always holds `BLK_LEN` valid bytes, 255 by default, and its first byte is presented with the start marker.

Top module: `fec_corr_stats`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, `dout_vld`, `first_out` and `stat_vld` are 0. A block cut short by reset never produces a status strobe.
- R2: For every input clock with `in_vld`=1, the next clock shows `dout_vld`=1 and `dout` = `fifo_byte` XOR `err_val`, when the block is correctable.
- R3: `first_out` is 1 only on the output clock of the byte that entered with `in_start`=1. It is 0 on every other byte and on idle clocks.
- R4: `stat_vld` is 1 for exactly one clock, two clocks after the clock on which the block's `BLK_LEN`-th byte is on `dout`. It is 0 at all other times.
- R5: During `stat_vld`, `cnt_1to0` equals the sum over the block of the number of bit positions where the FIFO byte is 1 and the applied error byte is 1.
- R6: During `stat_vld`, `cnt_0to1` equals the sum over the block of the number of bit positions where the FIFO byte is 0 and the applied error byte is 1.
- R7: Each count saturates at 255 (all ones in 8 bits) and never wraps.
- R8: `in_uncorr` is sampled only on the byte with `in_start`=1 and is ignored on all other bytes. When it is sampled as 1, every byte of that block leaves unchanged, `stat_uncorr` is 1 and both counts are 0 at `stat_vld`.
- R9: A byte with `in_start`=1 begins a new block. It clears both counts and the byte position, including when it arrives before the previous block has completed or directly after the previous block's last byte.
- R10: Clocks with `in_vld`=0 advance nothing: the next clock shows `dout_vld`=0, and the byte position and the counts hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | FIFO byte and error byte are valid this clock |
| in_start | input | 1 | This byte is the first of a block |
| in_uncorr | input | 1 | Block is uncorrectable (sampled with `in_start`) |
| fifo_byte | input | 8 | Original byte from the delay FIFO |
| err_val | input | 8 | Error value to XOR into the byte |
| dout | output | 8 | Corrected byte |
| dout_vld | output | 1 | `dout` carries a byte |
| first_out | output | 1 | `dout` carries the first byte of a block |
| stat_vld | output | 1 | One-clock status strobe |
| stat_uncorr | output | 1 | Block was uncorrectable (valid with `stat_vld`) |
| cnt_1to0 | output | 8 | Bits corrected from 1 to 0 (valid with `stat_vld`) |
| cnt_0to1 | output | 8 | Bits corrected from 0 to 1 (valid with `stat_vld`) |

## Verification
The hardest situation to reach is a status strobe for one block that falls while the next block is already streaming. The counters and the uncorrectable latch have by then been overwritten by the new block, so only the two-stage snapshot holds the right values. The stimulus table places blocks back to back with no idle clocks between them, including an uncorrectable block followed by a saturating one. It also restarts a block partway through and resets in the middle of a block. Both counters are driven to saturation, once both together and once only one of them.

// File: rtl/fec_corr_pkg.sv
package fec_corr_pkg;

  typedef enum logic {
    DIR_1TO0 = 1'b0,
    DIR_0TO1 = 1'b1
  } flip_dir_e;

  // number of set bits in a value of up to 16 bits
  function automatic logic [4:0] pop16(input logic [15:0] v);
    logic [4:0] n;
    n = '0;
    for (int i = 0; i < 16; i++) n = n + {4'd0, v[i]};
    return n;
  endfunction

  // add with a ceiling: the result never exceeds lim
  function automatic logic [15:0] sat_add(input logic [15:0] a,
                                          input logic [15:0] b,
                                          input logic [15:0] lim);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    return (s > {1'b0, lim}) ? lim : s[15:0];
  endfunction

endpackage

// File: rtl/corr_xor_stage.sv
module corr_xor_stage #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_vld,
  input  logic          in_start,
  input  logic          in_uncorr,
  input  logic [DW-1:0] fifo_byte,
  input  logic [DW-1:0] err_val,
  output logic [DW-1:0] eff_err,
  output logic          blk_bad_q,
  output logic [DW-1:0] dout,
  output logic          dout_vld,
  output logic          first_out
);

  logic bad_now;

  // the flag of the block this byte belongs to
  assign bad_now = in_start ? in_uncorr : blk_bad_q;
  assign eff_err = bad_now ? '0 : err_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_bad_q <= 1'b0;
      dout      <= '0;
      dout_vld  <= 1'b0;
      first_out <= 1'b0;
    end else begin
      dout_vld  <= in_vld;
      first_out <= in_vld & in_start;
      if (in_vld) begin
        dout <= fifo_byte ^ eff_err;
        if (in_start) blk_bad_q <= in_uncorr;
      end
    end
  end

  AST_PASS_UNCORR: assert property (@(posedge clk) disable iff (rst)
    (in_vld && bad_now) |=> (dout == $past(fifo_byte)));  // R8

  AST_FIRST_HAS_DATA: assert property (@(posedge clk) disable iff (rst)
    first_out |-> dout_vld);  // R3

endmodule

// File: rtl/corr_flip_counter.sv
module corr_flip_counter
  import fec_corr_pkg::*;
#(
  parameter int        DW    = 8,
  parameter int        CNT_W = 8,
  parameter flip_dir_e DIR   = DIR_1TO0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  input  logic             in_start,
  input  logic [DW-1:0]    fifo_byte,
  input  logic [DW-1:0]    eff_err,
  output logic [CNT_W-1:0] acc
);

  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic [DW-1:0]    flips;
  logic [4:0]       nflip;
  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] acc_nxt;

  generate
    if (DIR == DIR_1TO0) begin : g_hi_lo
      assign flips = fifo_byte & eff_err;
    end else begin : g_lo_hi
      assign flips = ~fifo_byte & eff_err;
    end
  endgenerate

  assign nflip   = pop16(16'(flips));
  assign base    = in_start ? '0 : acc;
  assign acc_nxt = CNT_W'(sat_add(16'(base), 16'(nflip), 16'(CNT_MAX)));

  always_ff @(posedge clk) begin
    if (rst)         acc <= '0;
    else if (in_vld) acc <= acc_nxt;
  end

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (in_vld && !in_start) |=> (acc >= $past(acc)));  // R7

  AST_GAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> $stable(acc));  // R10

endmodule

// File: rtl/corr_status_pipe.sv
module corr_status_pipe #(
  parameter int BLK_LEN = 255,
  parameter int CNT_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  input  logic             in_start,
  input  logic             blk_bad_q,
  input  logic [CNT_W-1:0] c10,
  input  logic [CNT_W-1:0] c01,
  output logic             last_out,
  output logic             stat_vld,
  output logic             stat_uncorr,
  output logic [CNT_W-1:0] stat_c10,
  output logic [CNT_W-1:0] stat_c01
);

  localparam int IW = $clog2(BLK_LEN + 1);

  logic [IW-1:0]    idx;
  logic [IW-1:0]    pos;
  logic             last_in;
  logic             p1_vld;
  logic             p1_unc;
  logic [CNT_W-1:0] p1_c10;
  logic [CNT_W-1:0] p1_c01;

  assign pos     = in_start ? '0 : idx;
  assign last_in = in_vld && (pos == IW'(BLK_LEN - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      idx         <= '0;
      last_out    <= 1'b0;
      p1_vld      <= 1'b0;
      p1_unc      <= 1'b0;
      p1_c10      <= '0;
      p1_c01      <= '0;
      stat_vld    <= 1'b0;
      stat_uncorr <= 1'b0;
      stat_c10    <= '0;
      stat_c01    <= '0;
    end else begin
      if (in_vld) idx <= pos + IW'(1);
      last_out <= last_in;
      // stage 1: snapshot while the last byte is on the output
      p1_vld <= last_out;
      if (last_out) begin
        p1_unc <= blk_bad_q;
        p1_c10 <= c10;
        p1_c01 <= c01;
      end
      // stage 2: present with the strobe
      stat_vld <= p1_vld;
      if (p1_vld) begin
        stat_uncorr <= p1_unc;
        stat_c10    <= p1_c10;
        stat_c01    <= p1_c01;
      end
    end
  end

  AST_STAT_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
    stat_vld |=> !stat_vld);  // R4

endmodule

// File: rtl/fec_corr_stats.sv
module fec_corr_stats
  import fec_corr_pkg::*;
#(
  parameter int DW      = 8,
  parameter int BLK_LEN = 255,
  parameter int CNT_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  input  logic             in_start,
  input  logic             in_uncorr,
  input  logic [DW-1:0]    fifo_byte,
  input  logic [DW-1:0]    err_val,
  output logic [DW-1:0]    dout,
  output logic             dout_vld,
  output logic             first_out,
  output logic             stat_vld,
  output logic             stat_uncorr,
  output logic [CNT_W-1:0] cnt_1to0,
  output logic [CNT_W-1:0] cnt_0to1
);

  logic [DW-1:0]    eff_err;
  logic             blk_bad_q;
  logic [CNT_W-1:0] acc_1to0;
  logic [CNT_W-1:0] acc_0to1;
  logic             last_out;

  corr_xor_stage #(.DW(DW)) u_xor (
    .clk       (clk),
    .rst       (rst),
    .in_vld    (in_vld),
    .in_start  (in_start),
    .in_uncorr (in_uncorr),
    .fifo_byte (fifo_byte),
    .err_val   (err_val),
    .eff_err   (eff_err),
    .blk_bad_q (blk_bad_q),
    .dout      (dout),
    .dout_vld  (dout_vld),
    .first_out (first_out)
  );

  corr_flip_counter #(.DW(DW), .CNT_W(CNT_W), .DIR(DIR_1TO0)) u_cnt_hi_lo (
    .clk       (clk),
    .rst       (rst),
    .in_vld    (in_vld),
    .in_start  (in_start),
    .fifo_byte (fifo_byte),
    .eff_err   (eff_err),
    .acc       (acc_1to0)
  );

  corr_flip_counter #(.DW(DW), .CNT_W(CNT_W), .DIR(DIR_0TO1)) u_cnt_lo_hi (
    .clk       (clk),
    .rst       (rst),
    .in_vld    (in_vld),
    .in_start  (in_start),
    .fifo_byte (fifo_byte),
    .eff_err   (eff_err),
    .acc       (acc_0to1)
  );

  corr_status_pipe #(.BLK_LEN(BLK_LEN), .CNT_W(CNT_W)) u_status (
    .clk         (clk),
    .rst         (rst),
    .in_vld      (in_vld),
    .in_start    (in_start),
    .blk_bad_q   (blk_bad_q),
    .c10         (acc_1to0),
    .c01         (acc_0to1),
    .last_out    (last_out),
    .stat_vld    (stat_vld),
    .stat_uncorr (stat_uncorr),
    .stat_c10    (cnt_1to0),
    .stat_c01    (cnt_0to1)
  );

  AST_LAST_IS_DATA: assert property (@(posedge clk) disable iff (rst)
    last_out |-> dout_vld);  // R4

  AST_STAT_AFTER_DATA: assert property (@(posedge clk) disable iff (rst)
    stat_vld |-> $past(dout_vld, 2));  // R4

  AST_UNCORR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (stat_vld && stat_uncorr) |-> (cnt_1to0 == '0 && cnt_0to1 == '0));  // R8

  AST_FIRST_SEEN_START: assert property (@(posedge clk) disable iff (rst)
    first_out |-> $past(in_start));  // R3

endmodule

// File: tb/fec_corr_stats_test.sv
module fec_corr_stats_test;

  localparam int BL = 255;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_vld = 1'b0, in_start = 1'b0, in_uncorr = 1'b0;
  logic [7:0] fifo_byte = '0, err_val = '0;
  logic [7:0] dout;
  logic       dout_vld, first_out, stat_vld, stat_uncorr;
  logic [7:0] cnt_1to0, cnt_0to1;

  fec_corr_stats uut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_start(in_start),
    .in_uncorr(in_uncorr), .fifo_byte(fifo_byte), .err_val(err_val),
    .dout(dout), .dout_vld(dout_vld), .first_out(first_out),
    .stat_vld(stat_vld), .stat_uncorr(stat_uncorr),
    .cnt_1to0(cnt_1to0), .cnt_0to1(cnt_0to1)
  );

  always #4 clk = ~clk;

  // vector: [7:0] seed, [9:8] err mode, [12] uncorrectable, [13] gaps, [19:16] idle after
  localparam logic [31:0] VEC [6] = '{
    32'h0004_010B, 32'h0000_1163, 32'h0000_2205,
    32'h0006_0300, 32'h0003_00C8, 32'h0005_214D
  };

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // bench model state
  bit       prev_vld = 0, prev_first = 0;
  logic [7:0] prev_exp = '0;
  bit       armed = 0, blk_bad = 0, snap_unc = 0;
  int       due = 0, bcount = 0, m10 = 0, m01 = 0, snap10 = 0, snap01 = 0;

  function automatic int bits(logic [7:0] v);
    int n = 0;
    while (v != 8'd0) begin v = v & 8'(v - 8'd1); n++; end
    return n;
  endfunction

  function automatic logic [7:0] fgen(logic [7:0] seed, int mode, int i);
    if (mode == 3) return 8'hFF;
    return 8'(seed + 8'(i * 37));
  endfunction

  function automatic logic [7:0] egen(int mode, int i);
    case (mode)
      1: return (i % 17 == 3) ? 8'(i | 1) : 8'h00;
      2: return 8'hFF;
      3: return 8'h03;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0d exp=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_outputs();
    chk(dout_vld == prev_vld, "R10", "dout_vld", dout_vld, prev_vld);
    chk(first_out == prev_first, "R3", "first_out", first_out, prev_first);
    if (prev_vld) chk(dout == prev_exp, "R2", "dout", dout, prev_exp);
    if (armed) begin
      due--;
      if (due == 0) begin
        armed = 0;
        chk(stat_vld == 1'b1, "R4", "stat_vld", stat_vld, 1);
        chk(stat_uncorr == snap_unc, "R8", "stat_uncorr", stat_uncorr, snap_unc);
        chk(int'(cnt_1to0) == snap10, "R5", "cnt_1to0", cnt_1to0, snap10);
        chk(int'(cnt_0to1) == snap01, "R6", "cnt_0to1", cnt_0to1, snap01);
      end else chk(stat_vld == 1'b0, "R4", "stat_vld early", stat_vld, 0);
    end else chk(stat_vld == 1'b0, "R4", "stat_vld spurious", stat_vld, 0);
  endtask

  task automatic step(bit v, bit s, bit u, logic [7:0] fb, logic [7:0] eb);
    logic [7:0] ee;
    @(negedge clk);
    check_outputs();
    if (v) begin
      if (s) begin blk_bad = u; m10 = 0; m01 = 0; bcount = 0; end
      ee = blk_bad ? 8'h00 : eb;
      prev_exp = fb ^ ee;
      m10 += bits(fb & ee);  if (m10 > 255) m10 = 255;  // R7 ceiling
      m01 += bits(~fb & ee); if (m01 > 255) m01 = 255;
      bcount++;
      if (bcount == BL) begin
        armed = 1; due = 3; snap_unc = blk_bad; snap10 = m10; snap01 = m01;
      end
    end
    prev_vld = v; prev_first = v && s;
    in_vld = v; in_start = s; in_uncorr = u; fifo_byte = fb; err_val = eb;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, 8'h00, 8'h00);
  endtask

  // the uncorrectable input toggles on non-start bytes to show it is ignored (R8)
  task automatic run_block(logic [7:0] seed, int mode, bit unc, bit gaps, int len);
    for (int i = 0; i < len; i++) begin
      step(1, i == 0, (i == 0) ? unc : ~unc, fgen(seed, mode, i), egen(mode, i));
      if (gaps && (i % 50 == 49)) idle(1);
    end
  endtask

  task automatic do_reset();
    rst = 1; in_vld = 0; in_start = 0; in_uncorr = 0; fifo_byte = '0; err_val = '0;
    repeat (3) @(negedge clk);
    chk(dout_vld == 0 && first_out == 0 && stat_vld == 0, "R1", "outputs in reset",
        {dout_vld, first_out, stat_vld}, 0);
    rst = 0;
    prev_vld = 0; prev_first = 0; armed = 0; due = 0; bcount = 0;
    @(negedge clk);
    chk(dout_vld == 0 && first_out == 0 && stat_vld == 0, "R1", "outputs after reset",
        {dout_vld, first_out, stat_vld}, 0);
  endtask

  initial begin
    do_reset();
    // table walk: back-to-back blocks, gaps, saturation, uncorrectable (R2-R10)
    for (int v = 0; v < 6; v++) begin
      run_block(VEC[v][7:0], int'(VEC[v][9:8]), VEC[v][12], VEC[v][13], BL);
      idle(int'(VEC[v][19:16]));
    end
    idle(4);
    // R9: restart partway through a block with heavy errors; only the new block counts
    run_block(8'h21, 2, 0, 0, 100);
    run_block(8'h37, 1, 0, 0, BL);
    idle(5);
    // R1: reset in the middle of a block, no strobe afterwards
    run_block(8'h10, 2, 0, 0, 120);
    do_reset();
    idle(8);
    // recovery after reset with fresh counts (R5, R6)
    run_block(8'h5A, 1, 0, 1, BL);
    idle(6);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule